// File: doc/BRIEF.md
# Debug Breakpoint Response Controller

This block decides how a processor core responds when a hardware breakpoint trigger fires. A two-bit response-select input chooses the action. One setting stops the core, and the status output then shows a fixed halted code until a resume strobe arrives. Another setting turns the trigger into a debug interrupt request. That request outranks every normal interrupt level, including the nonmaskable level 7. It waits for the core's next instruction-boundary sample point. The block then raises an exception-start request, supplies vector number 12 and its vector-table address, and shows the debug-exception status code for a minimum number of cycles.

An emulator-mode flag is set when debug exception processing begins. It can also be forced by a control bit, which is sampled only in the first cycle after synchronous reset is released. While the flag is set, the normal interrupt level forwarded to the core reads zero and new triggers are ignored. A return-from-exception completion strobe clears the flag. If the trigger input is still high at that point, a fresh debug request is raised. The breakpoint comparators, stack-frame building and instruction execution are outside this block and appear only as input strobes.

The state machine has five states. S_RUN is normal execution. S_PEND means a debug interrupt is waiting for a sample point. S_HALT means the core is stopped. S_EXC means debug exception entry is in progress. S_HNDL means the debug handler is running. The transitions are:
- trig_halt: S_RUN to S_HALT.
- trig_pend: S_RUN to S_PEND.
- trig_take: S_RUN to S_EXC, when the trigger and a sample point come in the same cycle.
- sample_take: S_PEND to S_EXC.
- resume: S_HALT to S_RUN.
- entry_done: S_EXC to S_HNDL.
- rte_exit: S_HNDL to S_RUN.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: While rst is high, the block returns to S_RUN at the next clock edge. There is then no pending request, halted is 0, emu_mode is 0, exc_req is 0, pst equals core_pst and irq_fwd equals irq_lvl.
- R2: With resp_sel = 2'b01, a brk_trig seen in S_RUN outside emulator mode stops the core from the next cycle. pst then reads 4'hF, halted is 1 and irq_fwd is 0. This holds until a cycle with resume high, and normal operation returns in the cycle after that.
- R3: With resp_sel = 2'b10, a brk_trig in S_RUN outside emulator mode leaves a debug request pending from the next cycle. The request stays pending, with irq_fwd forced to 0 even against level 7, until a cycle with sample_pt high. Exception entry begins in the cycle after that sample point.
- R4: A brk_trig with resp_sel = 2'b10 in the same cycle as sample_pt starts exception entry in the next cycle, with no pending cycle.
- R5: During exception entry pst reads 4'hD and exc_req stays 1 until exc_ack is seen. Entry lasts exactly PST_CYC cycles when exc_ack comes in its first cycle. It is extended until the cycle in which exc_ack arrives when the acknowledge is late.
- R6: exc_vec is always 12 and vec_addr is always vbr + 48.
- R7: Emulator mode is set in the first cycle of exception entry. While it is set, irq_fwd reads 0 and brk_trig starts nothing.
- R8: A rte_done pulse clears emulator mode in the next cycle. A rte_done pulse in S_HNDL also returns the block to S_RUN.
- R9: If brk_trig is still high with resp_sel = 2'b10 in the first cycle after the return, a new debug request is pending in the following cycle.
- R10: emu_force is loaded into emulator mode only in the first cycle after rst falls. Changes to it at any other time have no effect.
- R11: With resp_sel = 2'b00 or 2'b11, brk_trig is ignored and no request is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| resp_sel | input | 2 | Trigger response: 01 halt, 10 debug interrupt, 00/11 none |
| brk_trig | input | 1 | Breakpoint trigger from the comparators (level) |
| sample_pt | input | 1 | Instruction-boundary sample point strobe |
| resume | input | 1 | Leave the halted state |
| exc_ack | input | 1 | Core accepts the exception-start request |
| rte_done | input | 1 | Return-from-exception completed |
| emu_force | input | 1 | Force emulator mode at reset release |
| core_pst | input | PST_W | Status code supplied by the core |
| irq_lvl | input | IRQ_W | Normal interrupt level requested |
| vbr | input | ADDR_W | Vector table base address |
| pst | output | PST_W | Processor status output |
| halted | output | 1 | Core is held stopped |
| emu_mode | output | 1 | Emulator mode flag |
| exc_req | output | 1 | Debug exception start request |
| exc_vec | output | VEC_W | Exception vector number |
| vec_addr | output | ADDR_W | Vector table entry address |
| irq_fwd | output | IRQ_W | Interrupt level forwarded to the core, 0 when masked |

## Verification
The bench checks that a level-7 request is masked both while the debug request waits and while the handler runs. A design that ranked the nonmaskable level above the debug interrupt would show 7 on irq_fwd there. It counts the 0xD cycles both with a prompt acknowledge and with a late one, so an off-by-one timer or an exit that ignores the acknowledge shows up as a wrong status. It holds the trigger across a return so that the request must fire again, which a design with an edge-detected trigger would miss. It also changes the force bit outside the release cycle, which would wrongly flip the mode if the bit were sampled all the time. Reserved select codes are followed by sample points to expose any request left pending.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    typedef enum logic [2:0] {
        S_RUN,
        S_PEND,
        S_HALT,
        S_EXC,
        S_HNDL
    } brk_state_e;

    typedef enum logic [1:0] {
        RSP_NONE_A = 2'b00,
        RSP_HALT   = 2'b01,
        RSP_DBGIRQ = 2'b10,
        RSP_NONE_B = 2'b11
    } brk_resp_e;

    localparam logic [3:0] PST_HALTED = 4'hF;
    localparam logic [3:0] PST_DBGEXC = 4'hD;
    localparam int         DBG_VEC_NUM = 12;
    localparam int         VEC_BYTES   = 4;

endpackage

// File: rtl/dbg_brk_pst_timer.sv
module dbg_brk_pst_timer #(
    parameter int PST_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int CW = (PST_CYC > 1) ? $clog2(PST_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PST_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == LAST);

    // Counter saturates at the last cycle of the status window
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/dbg_brk_emu.sv
module dbg_brk_emu (
    input  logic clk,
    input  logic rst,
    input  logic force_in,
    input  logic enter,
    input  logic leave,
    output logic emu
);
    logic rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            emu   <= 1'b0;
            rel_q <= 1'b1;
        end else begin
            rel_q <= 1'b0;
            if (rel_q) begin
                emu <= force_in;
            end else if (enter) begin
                emu <= 1'b1;
            end else if (leave) begin
                emu <= 1'b0;
            end
        end
    end

    assert_enter_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (enter && !rel_q) |=> emu);

    assert_leave_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (leave && !enter && !rel_q) |=> !emu);

    assert_force_only_release_R10: assert property (@(posedge clk) disable iff (rst)
        (!rel_q && !enter && !leave) |=> $stable(emu));

endmodule

// File: rtl/dbg_brk_fsm.sv
module dbg_brk_fsm
    import dbg_brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] resp_sel,
    input  logic       brk_trig,
    input  logic       sample_pt,
    input  logic       resume,
    input  logic       exc_ack,
    input  logic       rte_done,
    input  logic       emu,
    input  logic       tmr_done,
    output brk_state_e state,
    output logic       ack_seen,
    output logic       enter_exc
);
    brk_state_e state_nx;
    logic       armed;

    assign armed = brk_trig && !emu;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_RUN: begin
                if (armed && resp_sel == RSP_HALT) begin
                    state_nx = S_HALT;                  // trig_halt
                end else if (armed && resp_sel == RSP_DBGIRQ) begin
                    state_nx = sample_pt ? S_EXC : S_PEND; // trig_take / trig_pend
                end
            end
            S_PEND: if (sample_pt) state_nx = S_EXC;    // sample_take
            S_HALT: if (resume) state_nx = S_RUN;       // resume
            S_EXC:  if (tmr_done && (ack_seen || exc_ack)) state_nx = S_HNDL; // entry_done
            S_HNDL: if (rte_done) state_nx = S_RUN;     // rte_exit
            default: state_nx = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_RUN;
            ack_seen <= 1'b0;
        end else begin
            state    <= state_nx;
            ack_seen <= (state == S_EXC) && (state_nx == S_EXC) && (ack_seen || exc_ack);
        end
    end

    assign enter_exc = (state != S_EXC) && (state_nx == S_EXC);

    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && armed && resp_sel == RSP_HALT) |=> state == S_HALT);

    assert_pend_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_PEND && !sample_pt) |=> state == S_PEND);

    assert_same_cycle_take_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && armed && resp_sel == RSP_DBGIRQ && sample_pt) |=> state == S_EXC);

    assert_reserved_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && (resp_sel == RSP_NONE_A || resp_sel == RSP_NONE_B)) |=> state == S_RUN);

endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
    import dbg_brk_pkg::*;
#(
    parameter int PST_CYC = 4,
    parameter int PST_W   = 4,
    parameter int IRQ_W   = 3,
    parameter int VEC_W   = 8,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        resp_sel,
    input  logic              brk_trig,
    input  logic              sample_pt,
    input  logic              resume,
    input  logic              exc_ack,
    input  logic              rte_done,
    input  logic              emu_force,
    input  logic [PST_W-1:0]  core_pst,
    input  logic [IRQ_W-1:0]  irq_lvl,
    input  logic [ADDR_W-1:0] vbr,
    output logic [PST_W-1:0]  pst,
    output logic              halted,
    output logic              emu_mode,
    output logic              exc_req,
    output logic [VEC_W-1:0]  exc_vec,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [IRQ_W-1:0]  irq_fwd
);
    localparam logic [ADDR_W-1:0] VEC_OFS = ADDR_W'(DBG_VEC_NUM * VEC_BYTES);

    brk_state_e state;
    logic       ack_seen;
    logic       enter_exc;
    logic       tmr_done;
    logic       emu;

    dbg_brk_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .resp_sel  (resp_sel),
        .brk_trig  (brk_trig),
        .sample_pt (sample_pt),
        .resume    (resume),
        .exc_ack   (exc_ack),
        .rte_done  (rte_done),
        .emu       (emu),
        .tmr_done  (tmr_done),
        .state     (state),
        .ack_seen  (ack_seen),
        .enter_exc (enter_exc)
    );

    dbg_brk_pst_timer #(.PST_CYC(PST_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .active (state == S_EXC),
        .done   (tmr_done)
    );

    dbg_brk_emu u_emu (
        .clk      (clk),
        .rst      (rst),
        .force_in (emu_force),
        .enter    (enter_exc),
        .leave    (rte_done),
        .emu      (emu)
    );

    always_comb begin
        pst      = core_pst;
        halted   = 1'b0;
        exc_req  = 1'b0;
        irq_fwd  = emu ? '0 : irq_lvl;
        unique case (state)
            S_RUN:   ;
            S_PEND:  irq_fwd = '0;
            S_HALT: begin
                pst     = PST_W'(PST_HALTED);
                halted  = 1'b1;
                irq_fwd = '0;
            end
            S_EXC: begin
                pst     = PST_W'(PST_DBGEXC);
                exc_req = !ack_seen;
                irq_fwd = '0;
            end
            S_HNDL:  irq_fwd = '0;
            default: ;
        endcase
    end

    assign emu_mode = emu;
    assign exc_vec  = VEC_W'(DBG_VEC_NUM);
    assign vec_addr = vbr + VEC_OFS;

    // Exception entry always runs in emulator mode
    assert_exc_in_emu_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXC) |-> emu);

    // Leaving entry only after the status window has elapsed
    assert_exc_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXC && !tmr_done) |=> state == S_EXC);

endmodule

// File: tb/sim_dbg_brk_ctrl.sv
module sim_dbg_brk_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  resp_sel = 2'b00;
    logic        brk_trig = 1'b0, sample_pt = 1'b0, resume = 1'b0;
    logic        exc_ack = 1'b0, rte_done = 1'b0, emu_force = 1'b0;
    logic [3:0]  core_pst = 4'h3;
    logic [2:0]  irq_lvl = 3'd5;
    logic [31:0] vbr = 32'h0000_1000;
    logic [3:0]  pst;
    logic        halted, emu_mode, exc_req;
    logic [7:0]  exc_vec;
    logic [31:0] vec_addr;
    logic [2:0]  irq_fwd;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string      tag;
        logic [3:0] pst;
        logic       emu;
        logic       hlt;
        logic       req;
        logic [2:0] irq;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;  // 50 MHz

    dbg_brk_ctrl u0 (
        .clk(clk), .rst(rst), .resp_sel(resp_sel), .brk_trig(brk_trig),
        .sample_pt(sample_pt), .resume(resume), .exc_ack(exc_ack),
        .rte_done(rte_done), .emu_force(emu_force), .core_pst(core_pst),
        .irq_lvl(irq_lvl), .vbr(vbr), .pst(pst), .halted(halted),
        .emu_mode(emu_mode), .exc_req(exc_req), .exc_vec(exc_vec),
        .vec_addr(vec_addr), .irq_fwd(irq_fwd)
    );

    // Monitor: compare outputs against the queued expectation for this cycle
    always @(negedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pst !== e.pst || emu_mode !== e.emu || halted !== e.hlt ||
                exc_req !== e.req || irq_fwd !== e.irq) begin
                errors++;
                $display("FAIL %s: got pst=%h emu=%b hlt=%b req=%b irq=%0d, expected pst=%h emu=%b hlt=%b req=%b irq=%0d",
                         e.tag, pst, emu_mode, halted, exc_req, irq_fwd,
                         e.pst, e.emu, e.hlt, e.req, e.irq);
            end
        end
    end

    // Driver: push the expectation for the current cycle, then advance one cycle
    task automatic ex(input string tag, input logic [3:0] p, input logic em,
                      input logic h, input logic rq, input logic [2:0] iq);
        exp_t e;
        e.tag = tag; e.pst = p; e.emu = em; e.hlt = h; e.req = rq; e.irq = iq;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic chk_vec(input string tag);
        checks++;
        if (exc_vec !== 8'd12 || vec_addr !== vbr + 32'd48) begin
            errors++;
            $display("FAIL %s: got vec=%0d addr=%h, expected vec=12 addr=%h",
                     tag, exc_vec, vec_addr, vbr + 32'd48);
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        // R1 reset state
        ex("R1 reset", 4'h3, 0, 0, 0, 3'd5);
        ex("R1 reset", 4'h3, 0, 0, 0, 3'd5);
        rst = 1'b0;
        ex("R1 release", 4'h3, 0, 0, 0, 3'd5);

        // R11 reserved select codes
        resp_sel = 2'b00; brk_trig = 1;
        ex("R11 sel00 trig", 4'h3, 0, 0, 0, 3'd5);
        brk_trig = 0; sample_pt = 1;
        ex("R11 sel00 no pend", 4'h3, 0, 0, 0, 3'd5);
        sample_pt = 0;
        ex("R11 sel00 no exc", 4'h3, 0, 0, 0, 3'd5);
        resp_sel = 2'b11; brk_trig = 1; sample_pt = 1;
        ex("R11 sel11 trig", 4'h3, 0, 0, 0, 3'd5);
        brk_trig = 0; sample_pt = 0;
        ex("R11 sel11 no exc", 4'h3, 0, 0, 0, 3'd5);

        // R2 halt response
        resp_sel = 2'b01; brk_trig = 1;
        ex("R2 trig", 4'h3, 0, 0, 0, 3'd5);
        brk_trig = 0;
        ex("R2 halted", 4'hF, 0, 1, 0, 3'd0);
        ex("R2 stays halted", 4'hF, 0, 1, 0, 3'd0);
        resume = 1;
        ex("R2 resume cycle", 4'hF, 0, 1, 0, 3'd0);
        resume = 0;
        ex("R2 running", 4'h3, 0, 0, 0, 3'd5);

        // R3 pending debug request, R5 prompt ack, R7, R8
        resp_sel = 2'b10; brk_trig = 1;
        ex("R3 trig", 4'h3, 0, 0, 0, 3'd5);
        brk_trig = 0; irq_lvl = 3'd7;
        ex("R3 pending masks level 7", 4'h3, 0, 0, 0, 3'd0);
        ex("R3 still pending", 4'h3, 0, 0, 0, 3'd0);
        sample_pt = 1;
        ex("R3 sample point", 4'h3, 0, 0, 0, 3'd0);
        sample_pt = 0; exc_ack = 1;
        chk_vec("R6 vector");
        ex("R5 entry c0", 4'hD, 1, 0, 1, 3'd0);
        exc_ack = 0;
        ex("R5 entry c1", 4'hD, 1, 0, 0, 3'd0);
        ex("R5 entry c2", 4'hD, 1, 0, 0, 3'd0);
        ex("R5 entry c3", 4'hD, 1, 0, 0, 3'd0);
        ex("R7 handler masks", 4'h3, 1, 0, 0, 3'd0);
        rte_done = 1;
        ex("R8 rte cycle", 4'h3, 1, 0, 0, 3'd0);
        rte_done = 0;
        ex("R8 emu cleared", 4'h3, 0, 0, 0, 3'd7);

        // R4 same-cycle take, R5 late ack, R9 re-fire
        brk_trig = 1; sample_pt = 1;
        ex("R4 trig at sample", 4'h3, 0, 0, 0, 3'd7);
        sample_pt = 0;
        ex("R4 entry c0", 4'hD, 1, 0, 1, 3'd0);
        ex("R5 late c1", 4'hD, 1, 0, 1, 3'd0);
        ex("R5 late c2", 4'hD, 1, 0, 1, 3'd0);
        ex("R5 late c3", 4'hD, 1, 0, 1, 3'd0);
        ex("R5 late extended", 4'hD, 1, 0, 1, 3'd0);
        exc_ack = 1;
        vbr = 32'h0002_0000;
        #1; chk_vec("R6 vector new base");
        ex("R5 late ack", 4'hD, 1, 0, 1, 3'd0);
        exc_ack = 0;
        ex("R7 trig ignored in handler", 4'h3, 1, 0, 0, 3'd0);
        rte_done = 1;
        ex("R8 rte", 4'h3, 1, 0, 0, 3'd0);
        rte_done = 0;
        ex("R9 back to run", 4'h3, 0, 0, 0, 3'd7);
        brk_trig = 0;
        ex("R9 re-raised pending", 4'h3, 0, 0, 0, 3'd0);
        sample_pt = 1;
        ex("R9 sample", 4'h3, 0, 0, 0, 3'd0);
        sample_pt = 0; exc_ack = 1;
        ex("R9 entry c0", 4'hD, 1, 0, 1, 3'd0);
        exc_ack = 0;
        ex("R9 entry c1", 4'hD, 1, 0, 0, 3'd0);
        ex("R9 entry c2", 4'hD, 1, 0, 0, 3'd0);
        ex("R9 entry c3", 4'hD, 1, 0, 0, 3'd0);
        rte_done = 1;
        ex("R9 handler", 4'h3, 1, 0, 0, 3'd0);
        rte_done = 0;
        ex("R9 returned", 4'h3, 0, 0, 0, 3'd7);

        // R10 forced emulator mode at reset release
        rst = 1; emu_force = 1;
        ex("R1 reset again", 4'h3, 0, 0, 0, 3'd7);
        rst = 0;
        ex("R10 release cycle", 4'h3, 0, 0, 0, 3'd7);
        emu_force = 0;
        ex("R10 forced emu", 4'h3, 1, 0, 0, 3'd0);
        brk_trig = 1; sample_pt = 1;
        ex("R7 trig while emu", 4'h3, 1, 0, 0, 3'd0);
        brk_trig = 0; sample_pt = 0;
        ex("R7 no entry while emu", 4'h3, 1, 0, 0, 3'd0);
        rte_done = 1;
        ex("R8 rte clears forced", 4'h3, 1, 0, 0, 3'd0);
        rte_done = 0; emu_force = 1;
        ex("R8 cleared", 4'h3, 0, 0, 0, 3'd7);
        ex("R10 force ignored late", 4'h3, 0, 0, 0, 3'd7);
        emu_force = 0;
        ex("R10 still clear", 4'h3, 0, 0, 0, 3'd7);

        @(negedge clk); #8;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule